// File: doc/BRIEF.md
# Status Word, Interrupt Gate and Register Bank Addressing Unit

This block keeps the 16-bit program status word of a small 8-bit processor. Each cycle the ALU offers the byte it produced together with its carry out of the top bit, its carry or borrow across the nibble boundary, its signed-overflow indication and, for shifts, the bit that fell out. A per-instruction mask selects which of the half-carry, negative, zero, overflow and carry flags take new values. All other flags keep their values. A separate write port loads the whole word at once. Software uses that port to set the bank pointer and the interrupt controls, and to restore the word on return from an interrupt.

The same word holds an interrupt enable bit and a 2-bit current interrupt level. A request comes with its own 2-bit level. The unit accepts the request in the same cycle when interrupts are enabled and the request outranks the current level. On acceptance it pulses an acknowledge, and the accepted level becomes the current level. The upper byte holds a 5-bit bank pointer. The unit turns this pointer and a 3-bit register index into the memory address of a banked general-purpose register.

Top module: `psw_unit`

## Requirements
- R1: While reset is low, the status word reads with the enable bit (bit 6) at 0 and the level field (bits 5:4) at 11. Every other bit reads 0.
- R2: A full-word write (`wr_en`=1) loads `wr_data` into the status word at the next clock edge. Bits 10:8 are stored as 0. A write in the same cycle as a flag update or an interrupt request takes precedence over both, and no acknowledge is given.
- R3: When mask bit 2 is set, Z (bit 2) becomes 1 exactly when the ALU result is 0x00. When mask bit 3 is set, N (bit 3) takes bit 7 of the result.
- R4: A flag whose mask bit is 0 keeps its value. The mask bits are: 4 for H, 3 for N, 2 for Z, 1 for V and 0 for C. With `wr_en` low, a zero mask and no acknowledge, the word does not change.
- R5: When its mask bit is set, C (bit 0) takes the shifted-out bit if `alu_shift` is 1, and the carry/borrow out of bit 7 otherwise. V (bit 1) takes the overflow input and H (bit 7) takes the nibble carry/borrow input.
- R6: `irq_ack` is high in the same cycle exactly when `irq_req` is 1, the enable bit is 1, `wr_en` is 0, and `irq_lvl` is numerically less than the current level. A smaller code means a higher priority.
- R7: After an acknowledge, the level field holds the accepted request level from the next cycle on. A current level of 00 blocks every request. A request coded 11 is never accepted.
- R8: `reg_addr` equals 0x0100 + 8 × bank pointer (bits 15:11) + `reg_idx`, combinationally. Bits 15:9 of this address are always 0 and bit 8 is always 1.
- R9: Bits 10:8 of the status word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the whole status word |
| wr_data | input | 16 | Word to load |
| upd_mask | input | 5 | Flag update select {H,N,Z,V,C} |
| alu_res | input | 8 | ALU result byte |
| alu_carry | input | 1 | Carry out of / borrow into bit 7 |
| alu_half | input | 1 | Carry or borrow between bits 3 and 4 |
| alu_ovf | input | 1 | Two's complement overflow |
| alu_shift | input | 1 | Current operation is a shift |
| alu_shout | input | 1 | Bit shifted out |
| irq_req | input | 1 | Maskable interrupt request |
| irq_lvl | input | 2 | Level of the request (00 most urgent) |
| irq_ack | output | 1 | Request accepted this cycle |
| reg_idx | input | 3 | Register index within the bank |
| psw | output | 16 | Current status word |
| reg_addr | output | 16 | Memory address of the indexed banked register |

## Verification
`irq_ack` and `reg_addr` are combinational results, so the bench checks them in the cycle the stimulus is applied. It drives its inputs just after a falling edge and samples these outputs one time step later, before the next rising edge. Word writes, flag updates and the level load from an acknowledge reach `psw` one clock later. The bench therefore compares `psw` with its model at the next falling edge, once the rising edge in between has registered the change.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int P_C   = 0;
   localparam int P_V   = 1;
   localparam int P_Z   = 2;
   localparam int P_N   = 3;
   localparam int P_IL0 = 4;
   localparam int P_IL1 = 5;
   localparam int P_I   = 6;
   localparam int P_H   = 7;

   localparam int M_C = 0;
   localparam int M_V = 1;
   localparam int M_Z = 2;
   localparam int M_N = 3;
   localparam int M_H = 4;
   localparam int MASK_W = 5;

   typedef struct packed {
      logic h;
      logic n;
      logic z;
      logic v;
      logic c;
   } flag_set_t;
endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
   import psw_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              carry,
   input  logic              half,
   input  logic              ovf,
   input  logic              is_shift,
   input  logic              shout,
   output flag_set_t         nxt
);
   if (DATA_W < 2) begin : g_chk
      $error("psw_flag_calc: DATA_W must be at least 2");
   end

   always_comb begin
      nxt.h = half;
      nxt.n = res[DATA_W-1];
      nxt.z = (res == '0);
      nxt.v = ovf;
      nxt.c = is_shift ? shout : carry;
   end
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
   parameter int LVL_W = 2
) (
   input  logic             enable,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic             req,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             block,
   output logic             ack
);
   if (LVL_W < 1) begin : g_chk
      $error("psw_irq_gate: LVL_W must be at least 1");
   end

   logic outranks;
   assign outranks = (req_lvl < cur_lvl);
   assign ack      = req & enable & outranks & ~block;
endmodule

// File: rtl/psw_bank_addr.sv
module psw_bank_addr #(
   parameter int          BANK_W = 5,
   parameter int          IDX_W  = 3,
   parameter int          ADDR_W = 16,
   parameter logic [15:0] BASE   = 16'h0100
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int OFS_W = BANK_W + IDX_W;
   localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << OFS_W) - 1);
   localparam bit BASE_ALIGNED = ((BASE_A & LOW_MASK) == '0);

   if (OFS_W > ADDR_W) begin : g_chk
      $error("psw_bank_addr: bank and index do not fit in the address");
   end

   logic [ADDR_W-1:0] offset;
   assign offset = {{(ADDR_W-OFS_W){1'b0}}, bank, idx};

   if (BASE_ALIGNED) begin : g_or
      assign addr = BASE_A | offset;
   end else begin : g_add
      assign addr = BASE_A + offset;
   end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
   import psw_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          BANK_W   = 5,
   parameter int          IDX_W    = 3,
   parameter int          LVL_W    = 2,
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] REG_BASE = 16'h0100
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2*DATA_W-1:0] wr_data,
   input  logic [MASK_W-1:0]   upd_mask,
   input  logic [DATA_W-1:0]   alu_res,
   input  logic                alu_carry,
   input  logic                alu_half,
   input  logic                alu_ovf,
   input  logic                alu_shift,
   input  logic                alu_shout,
   input  logic                irq_req,
   input  logic [LVL_W-1:0]    irq_lvl,
   output logic                irq_ack,
   input  logic [IDX_W-1:0]    reg_idx,
   output logic [2*DATA_W-1:0] psw,
   output logic [ADDR_W-1:0]   reg_addr
);
   localparam int PSW_W  = 2 * DATA_W;
   localparam int BANK_LO = PSW_W - BANK_W;
   localparam int PAD_W  = DATA_W - BANK_W;

   if (DATA_W != 8 || LVL_W != 2) begin : g_chk_layout
      $error("psw_unit: the low byte layout needs DATA_W=8 and LVL_W=2");
   end
   if (BANK_W > DATA_W) begin : g_chk_bank
      $error("psw_unit: bank pointer wider than the upper byte");
   end

   logic [BANK_W-1:0] bank_q;
   logic              h_q, i_q, n_q, z_q, v_q, c_q;
   logic [LVL_W-1:0]  il_q;
   flag_set_t         nxt;

   psw_flag_calc #(.DATA_W(DATA_W)) u_flags (
      .res      (alu_res),
      .carry    (alu_carry),
      .half     (alu_half),
      .ovf      (alu_ovf),
      .is_shift (alu_shift),
      .shout    (alu_shout),
      .nxt      (nxt)
   );

   psw_irq_gate #(.LVL_W(LVL_W)) u_gate (
      .enable  (i_q),
      .cur_lvl (il_q),
      .req     (irq_req),
      .req_lvl (irq_lvl),
      .block   (wr_en),
      .ack     (irq_ack)
   );

   psw_bank_addr #(
      .BANK_W (BANK_W),
      .IDX_W  (IDX_W),
      .ADDR_W (ADDR_W),
      .BASE   (REG_BASE)
   ) u_addr (
      .bank (bank_q),
      .idx  (reg_idx),
      .addr (reg_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
         h_q    <= 1'b0;
         i_q    <= 1'b0;
         il_q   <= '1;
         n_q    <= 1'b0;
         z_q    <= 1'b0;
         v_q    <= 1'b0;
         c_q    <= 1'b0;
      end else if (wr_en) begin
         bank_q <= wr_data[PSW_W-1 -: BANK_W];
         h_q    <= wr_data[P_H];
         i_q    <= wr_data[P_I];
         il_q   <= wr_data[P_IL1:P_IL0];
         n_q    <= wr_data[P_N];
         z_q    <= wr_data[P_Z];
         v_q    <= wr_data[P_V];
         c_q    <= wr_data[P_C];
      end else begin
         if (upd_mask[M_H]) h_q <= nxt.h;
         if (upd_mask[M_N]) n_q <= nxt.n;
         if (upd_mask[M_Z]) z_q <= nxt.z;
         if (upd_mask[M_V]) v_q <= nxt.v;
         if (upd_mask[M_C]) c_q <= nxt.c;
         if (irq_ack)       il_q <= irq_lvl;
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign psw = {bank_q, {PAD_W{1'b0}}, h_q, i_q, il_q, n_q, z_q, v_q, c_q};
   end else begin : g_nopad
      assign psw = {bank_q, h_q, i_q, il_q, n_q, z_q, v_q, c_q};
   end

   wire unused_lo = ^wr_data[BANK_LO-1:DATA_W];
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [4:0]  upd_mask,
   input logic        irq_req,
   input logic [1:0]  irq_lvl,
   input logic        irq_ack,
   input logic [15:0] psw,
   input logic [15:0] reg_addr
);
   // R1
   a_r1_reset_levels: assert property (@(posedge clk)
      !rst_n |=> (psw[6:4] == 3'b011));

   // R6
   a_r6_ack_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (irq_req && psw[6] && !wr_en && (irq_lvl < psw[5:4])));

   // R7
   a_r7_ack_loads_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (psw[5:4] == $past(irq_lvl)));

   // R7
   a_r7_zero_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (psw[5:4] == 2'b00) |-> !irq_ack);

   // R4
   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && upd_mask == 5'd0 && !irq_ack) |=> $stable(psw));

   // R8
   a_r8_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[15:9] == 7'd0) && reg_addr[8]);

   // R9
   a_r9_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      psw[10:8] == 3'd0);
endmodule

bind psw_unit psw_unit_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .upd_mask (upd_mask),
   .irq_req  (irq_req),
   .irq_lvl  (irq_lvl),
   .irq_ack  (irq_ack),
   .psw      (psw),
   .reg_addr (reg_addr)
);

// File: tb/psw_unit_tb_top.sv
`timescale 1ns/1ps
module psw_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [4:0]  upd_mask = '0;
   logic [7:0]  alu_res = '0;
   logic        alu_carry = 1'b0, alu_half = 1'b0, alu_ovf = 1'b0;
   logic        alu_shift = 1'b0, alu_shout = 1'b0;
   logic        irq_req = 1'b0;
   logic [1:0]  irq_lvl = '0;
   logic        irq_ack;
   logic [2:0]  reg_idx = '0;
   logic [15:0] psw;
   logic [15:0] reg_addr;

   int checks = 0;
   int fails  = 0;
   logic [15:0] m_psw;
   bit done = 0;

   always #5 clk = ~clk;

   psw_unit dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .upd_mask(upd_mask), .alu_res(alu_res), .alu_carry(alu_carry),
      .alu_half(alu_half), .alu_ovf(alu_ovf), .alu_shift(alu_shift),
      .alu_shout(alu_shout), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .irq_ack(irq_ack), .reg_idx(reg_idx), .psw(psw), .reg_addr(reg_addr)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic exp_ack(input logic [15:0] p);
      return irq_req && p[6] && !wr_en && (irq_lvl < p[5:4]);
   endfunction

   function automatic logic [15:0] exp_addr(input logic [15:0] p);
      return 16'h0100 + 16'(p[15:11]) * 16'd8 + 16'(reg_idx);
   endfunction

   function automatic logic [15:0] exp_next(input logic [15:0] p, input logic ack);
      logic [15:0] n = p;
      if (wr_en) begin
         n = wr_data;
         n[10:8] = 3'b000;
      end else begin
         if (upd_mask[4]) n[7] = alu_half;
         if (upd_mask[3]) n[3] = alu_res[7];
         if (upd_mask[2]) n[2] = (alu_res == 8'h00);
         if (upd_mask[1]) n[1] = alu_ovf;
         if (upd_mask[0]) n[0] = alu_shift ? alu_shout : alu_carry;
         if (ack) n[5:4] = irq_lvl;
      end
      return n;
   endfunction

   // inputs already set just after a falling edge
   task automatic step(input string tag);
      logic a;
      #1;
      a = exp_ack(m_psw);
      chk({tag, " R6 ack"}, {15'd0, irq_ack}, {15'd0, a});
      chk("R8 reg_addr", reg_addr, exp_addr(m_psw));
      m_psw = exp_next(m_psw, a);
      @(negedge clk);
      chk({tag, " R2/R3/R4/R5/R7 psw"}, psw, m_psw);
      chk("R9 pad bits", {13'd0, psw[10:8]}, 16'd0);
   endtask

   task automatic idle();
      wr_en = 0; upd_mask = '0; irq_req = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int s;
      s = $urandom(32'h1F2E3D4C);
      repeat (3) @(negedge clk);
      chk("R1 reset word", psw, 16'h0030);
      m_psw = 16'h0030;
      rst_n = 1'b1;

      // R6: enable 0 blocks
      idle(); irq_req = 1; irq_lvl = 2'b00; step("R6 disabled");
      // R2 write with pad bits set; enable, level 11, bank 31
      idle(); wr_en = 1; wr_data = 16'hFFF0 & 16'hFF70 | 16'h0040 | 16'h0030; step("R2 write");
      // R2 write blocks ack
      idle(); wr_en = 1; wr_data = 16'h0070; irq_req = 1; irq_lvl = 2'b00; step("R2 write beats ack");
      // R8 extremes
      idle(); wr_en = 1; wr_data = 16'hF870; reg_idx = 3'd7; step("R8 top bank");
      idle(); reg_idx = 3'd0; step("R8 top bank idx0");
      // R7 level 11 request never accepted, then 10 accepted
      idle(); irq_req = 1; irq_lvl = 2'b11; step("R7 req 11");
      idle(); irq_req = 1; irq_lvl = 2'b10; step("R7 accept 10");
      idle(); irq_req = 1; irq_lvl = 2'b10; step("R7 equal level blocked");
      idle(); irq_req = 1; irq_lvl = 2'b00; step("R7 accept 00");
      idle(); irq_req = 1; irq_lvl = 2'b00; step("R7 level 00 blocks");
      // R3 zero result, R5 shift and carry
      idle(); upd_mask = 5'h1F; alu_res = 8'h00; alu_carry = 1; alu_half = 1; alu_ovf = 1; alu_shift = 0; step("R3 zero");
      idle(); upd_mask = 5'h1F; alu_res = 8'h80; alu_carry = 1; alu_shift = 1; alu_shout = 0; step("R5 shift out");
      // R4 partial mask
      idle(); upd_mask = 5'b00100; alu_res = 8'h80; step("R4 Z only");
      idle(); step("R4 idle");

      for (int k = 0; k < 3000; k++) begin
         wr_en     = ($urandom % 8) == 0;
         wr_data   = 16'($urandom);
         upd_mask  = 5'($urandom);
         alu_res   = ($urandom % 6 == 0) ? 8'h00 : 8'($urandom);
         alu_carry = 1'($urandom);
         alu_half  = 1'($urandom);
         alu_ovf   = 1'($urandom);
         alu_shift = 1'($urandom);
         alu_shout = 1'($urandom);
         irq_req   = 1'($urandom);
         irq_lvl   = 2'($urandom);
         reg_idx   = 3'($urandom);
         step("random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule